// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address by following a four-level radix tree of translation tables kept in ordinary memory. A client offers one request that carries the virtual address and the frame number of the top-level table. The walker then reads one 8-byte entry per level through a simple memory read port and hands back either the physical address or a fault that names the level where the walk stopped. Each table holds 512 eight-byte entries, so a table fills exactly one 4 KB page.

The 36-bit virtual page number above the 12-bit page offset splits into four 9-bit indices. The top-level table uses the most significant index, and each lower level uses the next one down. The address of an entry is the table's frame number, then the 9-bit index, then three zero bits. In every entry, bit 0 is the present flag and bits 51:12 give the frame of the next table or, at the last level, the frame of the data page. The walker ignores all other entry bits. Only one walk is in flight at a time.

The controller has three states. ST_IDLE waits for a request. ST_FETCH holds a memory read open for the current level. ST_REPLY presents the result. The transitions are: ST_IDLE to ST_FETCH when a request is accepted. ST_FETCH to ST_FETCH when a present entry at levels 1 to 3 moves the walk one level down. ST_FETCH to ST_REPLY when an entry is not present, or when the level-4 entry is present. ST_REPLY to ST_IDLE when the client takes the result.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and right after it, req_ready is 1, and rsp_valid and mem_rd_req are 0.
- R2: The walker accepts a request only in ST_IDLE (req_ready=1 and req_valid=1 at a clock edge). req_ready stays 0 from that edge until the cycle after the result is taken. A request offered during a walk changes nothing.
- R3: The first read of a walk targets {req_root_frame, vaddr[47:39], 3'b000}. Each later read targets {frame from the previous entry, next index, 3'b000}, with the indices taken in the order vaddr[38:30], vaddr[29:21], vaddr[20:12].
- R4: mem_rd_req stays 1 with mem_rd_addr unchanged until a cycle in which mem_rsp_valid is 1. The walker ignores mem_rsp_valid whenever mem_rd_req is 0.
- R5: Bit 0 of an entry is the present flag, and bits 51:12 of a present entry are the next frame. Entry bits 63:52 and 11:1 have no effect.
- R6: When all four entries are present, the walk makes exactly four reads and returns rsp_fault=0, rsp_fault_level=0 and rsp_paddr = {level-4 entry bits 51:12, vaddr[11:0]}. A frame of zero is a valid result.
- R7: When the entry read at level L (1 = top, 4 = last) is not present, the walk stops after L reads and returns rsp_fault=1, rsp_fault_level=L and rsp_paddr=0.
- R8: While rsp_valid=1 and rsp_ready=0, the result outputs are held steady. The cycle after rsp_ready=1, rsp_valid is 0 and req_ready is 1.
- R9: A read may wait any number of cycles for its response, including zero extra cycles, and the result does not depend on that latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | The walker is idle and will accept a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_root_frame | input | 40 | Frame number of the top-level table |
| rsp_valid | output | 1 | A result is presented |
| rsp_ready | input | 1 | The client takes the result |
| rsp_fault | output | 1 | 1 when the walk hit a non-present entry |
| rsp_fault_level | output | 3 | Level of the non-present entry (1 to 4), 0 on success |
| rsp_paddr | output | 52 | Translated physical address, 0 on fault |
| mem_rd_req | output | 1 | A table-entry read is outstanding |
| mem_rd_addr | output | 52 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data is valid this cycle |
| mem_rsp_data | input | 64 | Table entry returned by memory |

## Verification
The bench targets index order and field placement. It uses all-zero and all-ones indices together with mappings that share upper levels and differ only lower down. A design that reversed the index order, or placed an index one bit off, would read the wrong entries and return wrong frames or spurious faults. It builds a non-present entry at each of the four levels, including a level-4 entry whose other bits are all set, to catch a walk that reports the wrong level, reads too many times, or treats a nonzero entry as present. Entries carry set bits in 63:52 and 11:1 to expose a decode that uses those bits. The bench also injects response strobes while the walker is idle, offers a second request during a walk, varies memory latency, and withholds rsp_ready. A design that took stray data, restarted the walk, changed its result under backpressure, or sampled data a cycle early would fail these checks.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W    = 48;
    localparam int PA_W    = 52;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 9;
    localparam int LEVELS  = 4;
    localparam int ENTRY_W = 64;

    // Walk controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_REPLY = 2'd2
    } walk_state_e;

endpackage

// File: rtl/ptw_va_slicer.sv
// Picks the table index for the current level out of the captured
// virtual address; level 0 is the top-level table.
module ptw_va_slicer #(
    parameter int VA_W   = ptw_pkg::VA_W,
    parameter int OFF_W  = ptw_pkg::OFF_W,
    parameter int IDX_W  = ptw_pkg::IDX_W,
    parameter int LEVELS = ptw_pkg::LEVELS,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] index,
    output logic [OFF_W-1:0] page_off
);

    logic [IDX_W-1:0] idx_by_level [LEVELS];

    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_slice
            // top level takes the most significant slice
            assign idx_by_level[g] = vaddr[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W];
        end
    endgenerate

    assign index    = idx_by_level[level];
    assign page_off = vaddr[OFF_W-1:0];

    logic unused_va_hi;
    generate
        if (VA_W > OFF_W + LEVELS*IDX_W) begin : g_hi
            assign unused_va_hi = ^vaddr[VA_W-1:OFF_W + LEVELS*IDX_W];
        end else begin : g_nohi
            assign unused_va_hi = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/ptw_entry_addr.sv
// Forms the byte address of a table entry: frame, index, entry-size zeros.
module ptw_entry_addr #(
    parameter int PA_W    = ptw_pkg::PA_W,
    parameter int OFF_W   = ptw_pkg::OFF_W,
    parameter int IDX_W   = ptw_pkg::IDX_W,
    parameter int ENTRY_W = ptw_pkg::ENTRY_W,
    localparam int FRAME_W = PA_W - OFF_W,
    localparam int ESZ_W   = $clog2(ENTRY_W/8)
) (
    input  logic [FRAME_W-1:0] table_frame,
    input  logic [IDX_W-1:0]   index,
    output logic [PA_W-1:0]    entry_addr
);

    // IDX_W + ESZ_W must equal OFF_W so a table fills one page
    assign entry_addr = {table_frame, index, {ESZ_W{1'b0}}};

endmodule

// File: rtl/ptw_entry_decode.sv
// Splits a table entry into its present flag and frame number.
module ptw_entry_decode #(
    parameter int PA_W    = ptw_pkg::PA_W,
    parameter int OFF_W   = ptw_pkg::OFF_W,
    parameter int ENTRY_W = ptw_pkg::ENTRY_W,
    localparam int FRAME_W = PA_W - OFF_W
) (
    input  logic [ENTRY_W-1:0] entry,
    output logic               present,
    output logic [FRAME_W-1:0] frame
);

    assign present = entry[0];
    assign frame   = entry[OFF_W +: FRAME_W];

    // flag bits 11:1 and bits above the frame carry no meaning here
    logic unused_entry_bits;
    assign unused_entry_bits = ^{entry[ENTRY_W-1:PA_W], entry[OFF_W-1:1]};

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int VA_W    = ptw_pkg::VA_W,
    parameter int PA_W    = ptw_pkg::PA_W,
    parameter int OFF_W   = ptw_pkg::OFF_W,
    parameter int IDX_W   = ptw_pkg::IDX_W,
    parameter int LEVELS  = ptw_pkg::LEVELS,
    parameter int ENTRY_W = ptw_pkg::ENTRY_W,
    localparam int FRAME_W = PA_W - OFF_W,
    localparam int LVL_W   = $clog2(LEVELS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [FRAME_W-1:0] req_root_frame,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic               rsp_fault,
    output logic [LVL_W:0]     rsp_fault_level,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               mem_rd_req,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rsp_valid,
    input  logic [ENTRY_W-1:0] mem_rsp_data
);

    import ptw_pkg::*;

    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);

    walk_state_e state_q, state_d;

    logic [VA_W-1:0]    va_q;
    logic [FRAME_W-1:0] frame_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [PA_W-1:0]    paddr_q;
    logic               fault_q;
    logic [LVL_W:0]     fault_lvl_q;

    logic [IDX_W-1:0]   cur_index;
    logic [OFF_W-1:0]   page_off;
    logic               ent_present;
    logic [FRAME_W-1:0] ent_frame;
    logic               last_lvl;
    logic               rsp_take;

    ptw_va_slicer #(
        .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
    ) slicer_i (
        .vaddr(va_q), .level(lvl_q), .index(cur_index), .page_off(page_off)
    );

    ptw_entry_addr #(
        .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)
    ) addr_i (
        .table_frame(frame_q), .index(cur_index), .entry_addr(mem_rd_addr)
    );

    ptw_entry_decode #(
        .PA_W(PA_W), .OFF_W(OFF_W), .ENTRY_W(ENTRY_W)
    ) decode_i (
        .entry(mem_rsp_data), .present(ent_present), .frame(ent_frame)
    );

    assign last_lvl = (lvl_q == LAST_LVL);
    assign rsp_take = (state_q == ST_FETCH) && mem_rsp_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_FETCH;
            ST_FETCH: if (mem_rsp_valid && (!ent_present || last_lvl)) state_d = ST_REPLY;
            ST_REPLY: if (rsp_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q        <= '0;
            frame_q     <= '0;
            lvl_q       <= '0;
            paddr_q     <= '0;
            fault_q     <= 1'b0;
            fault_lvl_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            va_q    <= req_vaddr;
            frame_q <= req_root_frame;
            lvl_q   <= '0;
        end else if (rsp_take) begin
            if (!ent_present) begin
                fault_q     <= 1'b1;
                fault_lvl_q <= {1'b0, lvl_q} + (LVL_W+1)'(1);
                paddr_q     <= '0;
            end else if (last_lvl) begin
                fault_q     <= 1'b0;
                fault_lvl_q <= '0;
                paddr_q     <= {ent_frame, page_off};
            end else begin
                frame_q <= ent_frame;
                lvl_q   <= lvl_q + LVL_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        req_ready       = (state_q == ST_IDLE);
        mem_rd_req      = (state_q == ST_FETCH);
        rsp_valid       = (state_q == ST_REPLY);
        rsp_fault       = fault_q;
        rsp_fault_level = fault_lvl_q;
        rsp_paddr       = paddr_q;
    end

    // R2
    req_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || rsp_valid) |-> !req_ready);

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rsp_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R5
    next_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rsp_valid && mem_rsp_data[0] && !last_lvl)
        |=> (mem_rd_req && mem_rd_addr[PA_W-1:OFF_W] == $past(mem_rsp_data[PA_W-1:OFF_W])));

    // R7
    fault_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |->
        (rsp_fault_level != '0 && rsp_fault_level <= (LVL_W+1)'(LEVELS) && rsp_paddr == '0));

    // R6
    ok_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_fault_level == '0));

    // R8
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
        (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_fault_level)));

endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb_top;

    typedef struct packed {
        logic [39:0] root;
        logic [8:0]  a;
        logic [8:0]  b;
        logic [8:0]  c;
        logic [8:0]  d;
        logic [11:0] off;
        logic [3:0]  delay;
        logic        fault;
        logic [2:0]  lvl;
        logic [39:0] pfn;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{40'h10, 9'd1,   9'd2,   9'd3,   9'd4,   12'h9A5, 4'd0,  1'b0, 3'd0, 40'hAB_CDEF_0123},
        '{40'h10, 9'd1,   9'd2,   9'd3,   9'd5,   12'hFFF, 4'd3,  1'b0, 3'd0, 40'h00_0000_0000},
        '{40'h10, 9'd511, 9'd511, 9'd511, 9'd511, 12'h000, 4'd1,  1'b0, 3'd0, 40'hFF_FFFF_FFFF},
        '{40'h10, 9'd0,   9'd0,   9'd0,   9'd0,   12'h001, 4'd5,  1'b0, 3'd0, 40'h00_0000_7777},
        '{40'h10, 9'd2,   9'd0,   9'd0,   9'd0,   12'h000, 4'd0,  1'b1, 3'd1, 40'h0},
        '{40'h10, 9'd1,   9'd7,   9'd0,   9'd0,   12'h000, 4'd2,  1'b1, 3'd2, 40'h0},
        '{40'h10, 9'd1,   9'd2,   9'd9,   9'd0,   12'h000, 4'd0,  1'b1, 3'd3, 40'h0},
        '{40'h10, 9'd1,   9'd2,   9'd3,   9'd6,   12'h123, 4'd1,  1'b1, 3'd4, 40'h0},
        '{40'h10, 9'd1,   9'd2,   9'd3,   9'd7,   12'h000, 4'd0,  1'b1, 3'd4, 40'h0},
        '{40'h20, 9'd1,   9'd2,   9'd3,   9'd4,   12'h456, 4'd2,  1'b0, 3'd0, 40'h00_0000_0055},
        '{40'h10, 9'd511, 9'd511, 9'd511, 9'd511, 12'hABC, 4'd12, 1'b0, 3'd0, 40'hFF_FFFF_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic [39:0] req_root_frame = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [2:0]  rsp_fault_level;
    logic [51:0] rsp_paddr;
    logic        mem_rd_req;
    logic [51:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] pt_mem [logic [51:0]];
    logic [39:0] next_frame = 40'h100;

    bit          resp_en = 1'b1;
    int          rsp_delay = 0;
    int          rd_count = 0;
    logic [51:0] first_addr = '0;

    always #5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root_frame(req_root_frame),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level),
        .rsp_paddr(rsp_paddr),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_read(input logic [51:0] addr);
        if (pt_mem.exists(addr)) return pt_mem[addr];
        return 64'h0;
    endfunction

    // installs a mapping; upper and flag bits are filled with noise (R5)
    task automatic map_page(input logic [39:0] root, input logic [8:0] ia, input logic [8:0] ib,
                            input logic [8:0] ic, input logic [8:0] id,
                            input logic [39:0] leaf, input bit present);
        logic [39:0] tbl;
        logic [8:0]  ix [4];
        logic [51:0] ea;
        tbl = root;
        ix[0] = ia; ix[1] = ib; ix[2] = ic; ix[3] = id;
        for (int l = 0; l < 3; l++) begin
            ea = {tbl, ix[l], 3'b000};
            if (pt_mem.exists(ea) && pt_mem[ea][0]) begin
                tbl = pt_mem[ea][51:12];
            end else begin
                tbl = next_frame;
                next_frame = next_frame + 40'd1;
                pt_mem[ea] = {12'h800, tbl, 12'h067};
            end
        end
        ea = {tbl, ix[3], 3'b000};
        pt_mem[ea] = present ? {12'hABC, leaf, 12'hFE1} : {12'hFFF, leaf, 12'hFFE};
    endtask

    // memory responder
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (resp_en) begin
                mem_rsp_valid = 1'b0;
                if (mem_rd_req) begin
                    if (cnt >= rsp_delay) begin
                        if (rd_count == 0) first_addr = mem_rd_addr;
                        mem_rsp_data  = mem_read(mem_rd_addr);
                        mem_rsp_valid = 1'b1;
                        rd_count++;
                        cnt = 0;
                    end else begin
                        cnt++;
                    end
                end else begin
                    cnt = 0;
                end
            end
        end
    end

    task automatic run_walk(input vec_t v, input int hold, input bit contend, input string tag);
        logic [47:0] va;
        logic [51:0] exp_pa;
        int          exp_rd;
        int          waited;
        va     = {v.a, v.b, v.c, v.d, v.off};
        exp_pa = v.fault ? 52'h0 : {v.pfn, v.off};
        exp_rd = v.fault ? int'(v.lvl) : 4;
        rsp_delay = int'(v.delay);
        rd_count  = 0;
        waited    = 0;
        @(negedge clk);
        req_vaddr = va;
        req_root_frame = v.root;
        req_valid = 1'b1;
        @(negedge clk);
        if (contend) begin
            req_vaddr = ~va;
            req_root_frame = 40'h20;
        end else begin
            req_valid = 1'b0;
        end
        chk(!req_ready, {"R2 ready low in walk ", tag}, 64'(req_ready), 64'h0);
        while (!rsp_valid && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
        req_valid = 1'b0;
        chk(rsp_valid, {"R9 result arrives ", tag}, 64'(rsp_valid), 64'h1);
        chk(rsp_fault == v.fault, {"R6/R7 fault flag ", tag}, 64'(rsp_fault), 64'(v.fault));
        chk(rsp_fault_level == v.lvl, {"R7 fault level ", tag}, 64'(rsp_fault_level), 64'(v.lvl));
        chk(rsp_paddr == exp_pa, {"R6 physical address ", tag}, 64'(rsp_paddr), 64'(exp_pa));
        chk(rd_count == exp_rd, {"R6/R7 read count ", tag}, 64'(rd_count), 64'(exp_rd));
        chk(first_addr == {v.root, v.a, 3'b000}, {"R3 first entry address ", tag},
            64'(first_addr), 64'({v.root, v.a, 3'b000}));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid && !req_ready && rsp_paddr == exp_pa, {"R8 result held ", tag},
                64'(rsp_paddr), 64'(exp_pa));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, {"R8 back to idle ", tag},
            64'({rsp_valid, req_ready}), 64'h1);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        map_page(40'h10, 9'd1,   9'd2,   9'd3,   9'd4,   40'hAB_CDEF_0123, 1'b1);
        map_page(40'h10, 9'd1,   9'd2,   9'd3,   9'd5,   40'h00_0000_0000, 1'b1);
        map_page(40'h10, 9'd511, 9'd511, 9'd511, 9'd511, 40'hFF_FFFF_FFFF, 1'b1);
        map_page(40'h10, 9'd0,   9'd0,   9'd0,   9'd0,   40'h00_0000_7777, 1'b1);
        map_page(40'h10, 9'd1,   9'd2,   9'd3,   9'd6,   40'hFF_FFFF_FFFF, 1'b0);
        map_page(40'h20, 9'd1,   9'd2,   9'd3,   9'd4,   40'h00_0000_0055, 1'b1);

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_rd_req, "R1 during reset",
            64'({req_ready, rsp_valid, mem_rd_req}), 64'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_rd_req, "R1 after reset",
            64'({req_ready, rsp_valid, mem_rd_req}), 64'h4);

        // vector table: R3 R5 R6 R7 R9
        for (int i = 0; i < NVEC; i++) begin
            run_walk(VECS[i], 0, 1'b0, $sformatf("vec%0d", i));
        end

        // R8 backpressure and R2 competing request
        run_walk(VECS[0], 5, 1'b1, "hold+contend");

        // R4 stray response strobes while idle
        resp_en = 1'b0;
        @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = 64'hFFFF_FFFF_FFFF_FFFF;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(req_ready && !rsp_valid && !mem_rd_req, "R4 stray strobe ignored",
                64'({req_ready, rsp_valid, mem_rd_req}), 64'h4);
        end
        mem_rsp_valid = 1'b0;
        resp_en = 1'b1;
        run_walk(VECS[3], 0, 1'b0, "after stray");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule